// File: doc/BRIEF.md
# Prescaled PWM Timer with Register Control

This block generates a single pulse-width-modulated output whose period is counted in ticks of a slow base tick. The base tick runs at 32 kHz and arrives as a one-clock enable pulse. Software programs the block through two byte-wide registers on a plain synchronous register strobe: address, write enable, write data, and a combinational read-back.

The control register holds a run flag and a two-bit prescaler field. The prescaler selects a period of 128, 64, 32 or 16 base ticks, which gives 250 Hz, 500 Hz, 1 kHz or 2 kHz. Each duty step is always one base tick (31.25 µs), so faster modes trade duty resolution for frequency. The duty register holds a seven-bit high-time count. The output is high for the first duty-count steps of every period.

A duty count of zero holds the line low. A count equal to or above the period's step count holds it high. Because the duty field is only seven bits wide, the slowest mode reaches at most 127/128 and never a full high. A write to either register acts on the next clock, and the period already running is not allowed to finish first.

Top module: `tick_pwm`

## Requirements
- R1: After synchronous reset, both registers read 0x00 and `pwm_out` is low.
- R2: Address 0 is the control register. Bit 7 is the run flag and bits [1:0] are the prescaler select. Bits [6:2] read back as zero whatever was written.
- R3: Address 1 is the duty register. Bits [6:0] are stored and bit 7 reads back as zero. Any other address reads 0x00, and a write to it changes neither register.
- R4: With the run flag set, one PWM period lasts (128 >> prescaler) base ticks. The step counter moves only on a clock where `tick` is high.
- R5: The output is high for the first D steps of each period and low for the rest, where D is the duty count. D = 0 gives a constant low output.
- R6: When D is at or above the step count of the selected mode, the output stays high. With prescaler 0 the largest D, 127, gives 127 high steps out of 128.
- R7: A register write changes `pwm_out` on the clock after the write, using the current step position. The running period is not completed first.
- R8: With the run flag clear, `pwm_out` is low and the step counter is held at zero. Setting the flag again starts a new period at step zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock base tick pulse at 32 kHz |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (4) | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` (combinational) |
| pwm_out | output | 1 | PWM output, normal polarity, registered |

## Verification
The two functions that can fall in the same cycle are a software write to the duty register and a step-counter advance on a base tick. Both act on the same registered output edge. The bench lowers the duty count in the middle of a period, after the counter has already passed the new value. It expects the line to drop on the very next clock instead of waiting for the period to wrap. It also restarts the counter by clearing and setting the run flag, then counts exact high clocks from step zero. A counter that was not reset, or a write that was deferred, would change that count.

// File: rtl/tick_pwm_pkg.sv
package tick_pwm_pkg;

    // Register data width
    localparam int DATA_W  = 8;
    // Prescaler field width
    localparam int PSEL_W  = 2;
    // Duty field width; also the step counter width
    localparam int DUTY_W  = 7;
    // Steps in the slowest period
    localparam int BASE_STEPS = 1 << DUTY_W;
    // Width able to hold BASE_STEPS itself
    localparam int STEPS_W = DUTY_W + 1;
    // Control bit positions (decoded by software)
    localparam int RUN_BIT = DATA_W - 1;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DUTY = 2'd1,
        SEL_NONE = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic              run;
        logic [PSEL_W-1:0] psel;
    } ctrl_t;

    typedef logic [DUTY_W-1:0]  step_t;
    typedef logic [STEPS_W-1:0] steps_t;

    // Steps in one period for a prescaler value
    function automatic steps_t period_steps(input logic [PSEL_W-1:0] psel);
        steps_t full;
        full = steps_t'(BASE_STEPS);
        return full >> psel;
    endfunction

    // Packs control state to its read-back byte
    function automatic logic [DATA_W-1:0] ctrl_to_byte(input ctrl_t c);
        logic [DATA_W-1:0] b;
        b = '0;
        b[RUN_BIT] = c.run;
        b[PSEL_W-1:0] = c.psel;
        return b;
    endfunction

endpackage

// File: rtl/tick_pwm_regs.sv
module tick_pwm_regs
    import tick_pwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output step_t             duty
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] DUTY_ADDR = ADDR_W'(1);

    reg_sel_e sel;

    always_comb begin
        if (addr == CTRL_ADDR)      sel = SEL_CTRL;
        else if (addr == DUTY_ADDR) sel = SEL_DUTY;
        else                        sel = SEL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            duty <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL: begin
                    ctrl.run  <= wdata[RUN_BIT];
                    ctrl.psel <= wdata[PSEL_W-1:0];
                end
                SEL_DUTY: duty <= wdata[DUTY_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_CTRL: rdata = ctrl_to_byte(ctrl);
            SEL_DUTY: rdata = DATA_W'(duty);
            default:  rdata = '0;
        endcase
    end

    // R3: a duty write lands in the register on the next clock
    p_duty_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == DUTY_ADDR) |=> (duty == $past(wdata[DUTY_W-1:0])));

    // R3: a write to an unmapped address leaves both registers unchanged
    p_unmapped_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr != CTRL_ADDR && addr != DUTY_ADDR) |=> ($stable(duty) && $stable(ctrl)));

    // R2: control write captures run flag and prescaler
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CTRL_ADDR) |=> (ctrl.run == $past(wdata[RUN_BIT])));

endmodule

// File: rtl/tick_pwm_counter.sv
module tick_pwm_counter
    import tick_pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  ctrl_t ctrl,
    output step_t step
);

    steps_t limit;
    steps_t step_inc;
    logic   wrap;

    always_comb begin
        limit    = period_steps(ctrl.psel);
        step_inc = {1'b0, step} + steps_t'(1);
        // Also wraps when a prescaler change left the counter past the end
        wrap     = (step_inc >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || !ctrl.run) begin
            step <= '0;
        end else if (tick) begin
            step <= wrap ? '0 : step_inc[DUTY_W-1:0];
        end
    end

    // R4: counter moves only on a tick
    p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && !tick) |=> $stable(step));

    // R8: counter sits at zero while stopped
    p_stopped_at_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run) |=> (step == '0));

    // R4: a tick advances by one or wraps to zero
    p_advance_or_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && tick && $past(ctrl.run)) |=>
            (step == '0 || step == $past(step) + step_t'(1)));

endmodule

// File: rtl/tick_pwm_compare.sv
module tick_pwm_compare
    import tick_pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  step_t duty,
    input  step_t step,
    output logic  pwm_out
);

    steps_t limit;
    logic   saturate;
    logic   in_high;
    logic   level_d;

    always_comb begin
        limit    = period_steps(ctrl.psel);
        saturate = ({1'b0, duty} >= limit);
        in_high  = (step < duty);
        level_d  = ctrl.run && (saturate || in_high);
    end

    always_ff @(posedge clk) begin
        if (rst) pwm_out <= 1'b0;
        else     pwm_out <= level_d;
    end

    // R5: zero duty never drives high
    p_zero_duty_low_r5: assert property (@(posedge clk) disable iff (rst)
        (duty == '0) |=> !pwm_out);

    // R6: duty at or above the step count holds the line high
    p_saturate_high_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && {1'b0, duty} >= period_steps(ctrl.psel)) |=> pwm_out);

    // R8: stopped timer drives low
    p_stopped_low_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run) |=> !pwm_out);

    // R7: output tracks the current step on the next clock
    p_step_past_duty_low_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && step >= duty && {1'b0, duty} < period_steps(ctrl.psel)) |=> !pwm_out);

endmodule

// File: rtl/tick_pwm.sv
module tick_pwm
    import tick_pwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              pwm_out
);

    ctrl_t ctrl;
    step_t duty;
    step_t step;

    tick_pwm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .ctrl  (ctrl),
        .duty  (duty)
    );

    tick_pwm_counter u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .ctrl (ctrl),
        .step (step)
    );

    tick_pwm_compare u_cmp (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .duty    (duty),
        .step    (step),
        .pwm_out (pwm_out)
    );

    // R1: output held low in the clock following reset
    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> !pwm_out);

endmodule

// File: tb/sim_tick_pwm.sv
module sim_tick_pwm;

    localparam int D  = 4;   // clocks per base tick in this bench
    localparam int NV = 12;

    // psel, duty, expected high steps per period
    localparam int V_PSEL [NV] = '{0, 0, 0,  0,   1,  1,  1,  2, 2,  3,  3,  3};
    localparam int V_DUTY [NV] = '{0, 1, 64, 127, 32, 64, 127, 5, 32, 15, 16, 127};
    localparam int V_EXP  [NV] = '{0, 1, 64, 127, 32, 64, 64,  5, 32, 15, 16, 16};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pwm_out;

    int checks = 0;
    int fails  = 0;
    int hi     = 0;
    int rises  = 0;
    logic prev = 1'b0;
    bit done = 0;

    always #5 clk = ~clk;

    tick_pwm u0 (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock; entered and left at a negedge; counts samples
    task automatic step1(input logic t);
        tick = t;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        if (pwm_out) hi++;
        if (pwm_out && !prev) rises++;
        prev = pwm_out;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            for (int j = 0; j < D - 1; j++) step1(1'b0);
            step1(1'b1);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        prev = pwm_out;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    int v;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(4'd0, v); chk("R1 ctrl", v, 0);
        rd(4'd1, v); chk("R1 duty", v, 0);
        chk("R1 out", int'(pwm_out), 0);

        // R2 / R3: read-back masking and unmapped address
        wr(4'd0, 8'hFF); rd(4'd0, v); chk("R2 ctrl readback", v, 8'h83);
        wr(4'd0, 8'h00);
        wr(4'd1, 8'hFF); rd(4'd1, v); chk("R3 duty readback", v, 8'h7F);
        wr(4'd2, 8'h55); rd(4'd2, v); chk("R3 unmapped read", v, 0);
        rd(4'd1, v); chk("R3 unmapped write duty", v, 8'h7F);
        rd(4'd0, v); chk("R3 unmapped write ctrl", v, 0);
        chk("R8 stopped low", int'(pwm_out), 0);

        // R5 / R6 / R4: vector table, high clocks over one period
        for (int k = 0; k < NV; k++) begin
            int steps;
            steps = 128 >> V_PSEL[k];
            wr(4'd0, 8'h80 | 8'(V_PSEL[k]));
            wr(4'd1, 8'(V_DUTY[k]));
            run_ticks(steps);
            hi = 0;
            run_ticks(steps);
            chk($sformatf("R5/R6 vec %0d", k), hi, V_EXP[k] * D);
        end

        // R8: stop then restart from step zero
        wr(4'd0, 8'h83);
        wr(4'd1, 8'd4);
        run_ticks(7);
        wr(4'd0, 8'h03);
        step1(1'b1);
        chk("R8 low when stopped", int'(pwm_out), 0);
        run_ticks(3);
        chk("R8 still low", int'(pwm_out), 0);
        wr(4'd0, 8'h83);
        hi = 0;
        run_ticks(16);
        chk("R8 restart at step zero", hi, 4 * D);

        // R4: period length, counted as rising edges over three periods
        wr(4'd0, 8'h02);
        wr(4'd1, 8'd5);
        wr(4'd0, 8'h82);
        prev = 1'b0; rises = 0; hi = 0;
        run_ticks(3 * 32);
        chk("R4 rises in three periods", rises, 3);
        chk("R4 high clocks in three periods", hi, 3 * 5 * D);

        // R7: duty lowered mid-period acts on the next clock
        wr(4'd0, 8'h80);
        wr(4'd1, 8'd100);
        run_ticks(50);
        chk("R7 high before change", int'(pwm_out), 1);
        wr(4'd1, 8'd10);
        step1(1'b0);
        chk("R7 low right after change", int'(pwm_out), 0);
        // R7: raising duty past the step reasserts at once
        wr(4'd1, 8'd120);
        step1(1'b0);
        chk("R7 high right after raise", int'(pwm_out), 1);

        // R1: reset clears running state
        rst = 1'b1;
        step1(1'b0);
        rst = 1'b0;
        chk("R1 out after reset", int'(pwm_out), 0);
        rd(4'd0, v); chk("R1 ctrl after reset", v, 0);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule